// File: doc/BRIEF.md
# Carrier Lock Detector Sequencer

This block judges whether a carrier tracking loop has really locked. On every valid sample it takes a signed phase error and a signed frequency (false-lock) error. It adds the magnitude of each to its own accumulator, and each accumulator starts from a preload value set by software. An integration counter counts the samples of the current integration period. The outcome of each period is a race. If the counter reaches the end of the period before an accumulator carries out, the error was small. If an accumulator carries out first, the error was large. A four-state sequencer uses these races to step through searching, verifying, sweeping out of a false lock, and locked. It picks the acquisition or tracking preloads and period length, drives the enable of an external frequency sweep, and raises a lock flag.

The block also has an external-control mode for loops that a processor supervises. In that mode the sequencer holds its state. The accumulators run for exactly one integration period, then freeze so their totals can be read, and a one-cycle interrupt pulse marks the end of the period. An initialize command restarts a period in either mode.

Top module: `carrier_lock_fsm`

## Requirements
- R1: While reset is high and after it is released, the state is search (state_out 0), locked is 0, sweep_en is 1, track_sel is 0, int_pulse is 0, and the accumulators hold the acquisition preloads.
- R2: A sample with smp_valid high adds |error| to each accumulator. A sample with smp_valid low changes nothing. The most negative input counts as the largest positive magnitude (-128 adds 127 for 8-bit errors).
- R3: In search, a period whose rollover arrives with no phase carry moves the block to verify (state_out 1), with sweep_en 0 and track_sel 1. A phase carry in search restarts the period and the state stays search.
- R4: In verify, verify_n consecutive clean periods (rollover with no carry) lead to lock (state_out 3). A phase carry in verify returns the block to search.
- R5: In verify, a carry of the false-lock accumulator before the rollover moves the block to sweep (state_out 2) with sweep_en 1 and track_sel 0.
- R6: In sweep, the block stays for sweep_n acquisition periods whatever the accumulators do, then returns to search.
- R7: In lock, locked is 1, a carry of the false-lock accumulator has no effect, and the block stays locked while each rollover comes first.
- R8: In lock, a phase carry drops locked and returns the block to search. This also holds when the carry and the rollover fall on the same sample.
- R9: At every end of a period and on init_cmd, the counter clears and each accumulator loads the preload of the set (acquisition or tracking) that the new state uses.
- R10: With ext_mode high, the state does not change. After the sample that ends the period, both accumulators hold their totals until init_cmd.
- R11: int_pulse is high for exactly the one cycle after the sample that ends a period in ext_mode. It stays low in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| phase_err | input | ERR_W | Signed phase error |
| freq_err | input | ERR_W | Signed false-lock / frequency error |
| ext_mode | input | 1 | External-control mode |
| init_cmd | input | 1 | Restart the integration period |
| acq_phase_pre | input | ACC_W | Phase accumulator preload, acquisition |
| trk_phase_pre | input | ACC_W | Phase accumulator preload, tracking |
| acq_fl_pre | input | ACC_W | False-lock accumulator preload, acquisition |
| trk_fl_pre | input | ACC_W | False-lock accumulator preload, tracking |
| acq_period | input | CNT_W | Samples per period, acquisition |
| trk_period | input | CNT_W | Samples per period, tracking |
| verify_n | input | DWELL_W | Clean periods needed to confirm lock |
| sweep_n | input | DWELL_W | Periods spent sweeping after a false lock |
| locked | output | 1 | Lock status |
| sweep_en | output | 1 | Frequency sweep enable |
| track_sel | output | 1 | Tracking parameter set in use |
| int_pulse | output | 1 | End-of-period interrupt (external mode) |
| phase_acc | output | ACC_W | Phase accumulator value |
| fl_acc | output | ACC_W | False-lock accumulator value |
| state_out | output | 2 | Sequencer state: 0 search, 1 verify, 2 sweep, 3 lock |

## Verification
The hardest situations to reach are the ones where two races resolve on the same sample, such as a phase carry that lands on the final sample of a lock period. Natural error magnitudes almost never produce this timing. The stimulus forces it by loading a preload just below the carry point through init_cmd, and then placing one large sample at the exact count of the rollover. The false-lock escape path is reached the same way: the tracking false-lock preload is raised and init_cmd is issued while the block is in verify, so that a single sample decides the outcome.

// File: rtl/cld_pkg.sv
package cld_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_SWEEP  = 2'd2,
        ST_LOCK   = 2'd3
    } lk_state_t;

    typedef struct packed {
        logic ph_ovf;
        logic fl_ovf;
        logic roll;
    } period_evt_t;

    function automatic logic uses_track(lk_state_t s);
        return (s == ST_VERIFY) || (s == ST_LOCK);
    endfunction

endpackage

// File: rtl/cld_accum.sv
module cld_accum #(
    parameter int ERR_W = 8,
    parameter int ACC_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    en,
    input  logic [ACC_W-1:0]        preload,
    input  logic signed [ERR_W-1:0] err,
    output logic [ACC_W-1:0]        acc,
    output logic                    ovf
);
    localparam int MAG_W = ERR_W - 1;
    localparam int SUM_W = ACC_W + 1;
    localparam logic [MAG_W-1:0] MAG_MAX = '1;

    logic [MAG_W-1:0] mag;
    logic [SUM_W-1:0] sum;

    always_comb begin
        if (!err[ERR_W-1])
            mag = err[MAG_W-1:0];
        else if (err[MAG_W-1:0] == '0)
            mag = MAG_MAX;
        else
            mag = MAG_W'(-err);
    end

    assign sum = {1'b0, acc} + SUM_W'(mag);
    assign ovf = en && sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst || load)
            acc <= preload;
        else if (en)
            acc <= sum[ACC_W-1:0];
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(acc));

endmodule

// File: rtl/cld_intcnt.sv
module cld_intcnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             roll
);
    assign roll = en && (cnt == period - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= roll ? '0 : cnt + CNT_W'(1);
    end

endmodule

// File: rtl/cld_seq.sv
module cld_seq
    import cld_pkg::*;
#(
    parameter int DWELL_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic               ext_mode,
    input  logic               init_cmd,
    input  period_evt_t        evt,
    input  logic [DWELL_W-1:0] verify_n,
    input  logic [DWELL_W-1:0] sweep_n,
    output lk_state_t          state,
    output logic               acc_en,
    output logic               restart,
    output logic               sel_next_trk,
    output logic               hold,
    output logic               int_pulse,
    output logic               locked,
    output logic               sweep_en,
    output logic               track_sel
);
    localparam int DW1 = DWELL_W + 1;

    lk_state_t          nxt;
    logic [DWELL_W-1:0] dwell, dwell_nxt;
    logic               evt_auto;
    logic [DW1-1:0]     dwell_inc;

    assign acc_en    = smp_valid && !hold && !init_cmd;
    assign dwell_inc = DW1'(dwell) + DW1'(1);

    always_comb begin
        nxt       = state;
        evt_auto  = 1'b0;
        dwell_nxt = dwell;
        if (!ext_mode && acc_en) begin
            case (state)
                ST_SEARCH: begin
                    if (evt.ph_ovf) begin
                        evt_auto = 1'b1;
                    end else if (evt.roll) begin
                        evt_auto = 1'b1;
                        nxt      = ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (evt.ph_ovf) begin
                        evt_auto = 1'b1;
                        nxt      = ST_SEARCH;
                    end else if (evt.fl_ovf) begin
                        evt_auto = 1'b1;
                        nxt      = ST_SWEEP;
                    end else if (evt.roll) begin
                        evt_auto = 1'b1;
                        if (dwell_inc >= DW1'(verify_n))
                            nxt = ST_LOCK;
                        else
                            dwell_nxt = dwell + DWELL_W'(1);
                    end
                end
                ST_SWEEP: begin
                    if (evt.roll) begin
                        evt_auto = 1'b1;
                        if (dwell_inc >= DW1'(sweep_n))
                            nxt = ST_SEARCH;
                        else
                            dwell_nxt = dwell + DWELL_W'(1);
                    end
                end
                ST_LOCK: begin
                    if (evt.ph_ovf) begin
                        evt_auto = 1'b1;
                        nxt      = ST_SEARCH;
                    end else if (evt.roll) begin
                        evt_auto = 1'b1;
                    end
                end
                default: nxt = ST_SEARCH;
            endcase
        end
        if (nxt != state)
            dwell_nxt = '0;
    end

    assign restart      = init_cmd || evt_auto;
    assign sel_next_trk = rst ? 1'b0 : uses_track(nxt);
    assign locked       = (state == ST_LOCK);
    assign sweep_en     = (state == ST_SEARCH) || (state == ST_SWEEP);
    assign track_sel    = uses_track(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SEARCH;
            dwell     <= '0;
            hold      <= 1'b0;
            int_pulse <= 1'b0;
        end else begin
            state     <= nxt;
            dwell     <= dwell_nxt;
            int_pulse <= ext_mode && acc_en && evt.roll;
            if (init_cmd || !ext_mode)
                hold <= 1'b0;
            else if (acc_en && evt.roll)
                hold <= 1'b1;
        end
    end

    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && !ext_mode && acc_en && evt.ph_ovf) |=> (state == ST_SEARCH && !locked));

    // R5
    false_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VERIFY && !ext_mode && acc_en && evt.fl_ovf && !evt.ph_ovf) |=> (state == ST_SWEEP));

    // R4
    lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(state) == ST_VERIFY));

    // R11
    int_single_chk: assert property (@(posedge clk) disable iff (rst)
        int_pulse |=> !int_pulse);

    // R10
    ext_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ext_mode |=> $stable(state));

endmodule

// File: rtl/carrier_lock_fsm.sv
module carrier_lock_fsm
    import cld_pkg::*;
#(
    parameter int ERR_W   = 8,
    parameter int ACC_W   = 10,
    parameter int CNT_W   = 6,
    parameter int DWELL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [ERR_W-1:0] phase_err,
    input  logic signed [ERR_W-1:0] freq_err,
    input  logic                    ext_mode,
    input  logic                    init_cmd,
    input  logic [ACC_W-1:0]        acq_phase_pre,
    input  logic [ACC_W-1:0]        trk_phase_pre,
    input  logic [ACC_W-1:0]        acq_fl_pre,
    input  logic [ACC_W-1:0]        trk_fl_pre,
    input  logic [CNT_W-1:0]        acq_period,
    input  logic [CNT_W-1:0]        trk_period,
    input  logic [DWELL_W-1:0]      verify_n,
    input  logic [DWELL_W-1:0]      sweep_n,
    output logic                    locked,
    output logic                    sweep_en,
    output logic                    track_sel,
    output logic                    int_pulse,
    output logic [ACC_W-1:0]        phase_acc,
    output logic [ACC_W-1:0]        fl_acc,
    output logic [1:0]              state_out
);
    lk_state_t        state;
    period_evt_t      evt;
    logic             acc_en, restart, sel_next_trk, hold;
    logic             ph_ovf, fl_ovf, roll;
    logic [ACC_W-1:0] ph_pre, fl_pre;
    logic [CNT_W-1:0] period, cnt;

    assign ph_pre = sel_next_trk ? trk_phase_pre : acq_phase_pre;
    assign fl_pre = sel_next_trk ? trk_fl_pre    : acq_fl_pre;
    assign period = track_sel    ? trk_period    : acq_period;
    assign evt    = '{ph_ovf: ph_ovf, fl_ovf: fl_ovf, roll: roll};
    assign state_out = state;

    cld_accum #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_ph_acc (
        .clk(clk), .rst(rst), .load(restart), .en(acc_en),
        .preload(ph_pre), .err(phase_err), .acc(phase_acc), .ovf(ph_ovf)
    );

    cld_accum #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_fl_acc (
        .clk(clk), .rst(rst), .load(restart), .en(acc_en),
        .preload(fl_pre), .err(freq_err), .acc(fl_acc), .ovf(fl_ovf)
    );

    cld_intcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(restart), .en(acc_en),
        .period(period), .cnt(cnt), .roll(roll)
    );

    cld_seq #(.DWELL_W(DWELL_W)) u_seq (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .ext_mode(ext_mode),
        .init_cmd(init_cmd), .evt(evt), .verify_n(verify_n), .sweep_n(sweep_n),
        .state(state), .acc_en(acc_en), .restart(restart),
        .sel_next_trk(sel_next_trk), .hold(hold), .int_pulse(int_pulse),
        .locked(locked), .sweep_en(sweep_en), .track_sel(track_sel)
    );

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R10
    held_accum_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !init_cmd) |=> ($stable(phase_acc) && $stable(fl_acc)));

endmodule

// File: tb/sim_carrier_lock_fsm.sv
`timescale 1ns/1ps
module sim_carrier_lock_fsm;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic signed [7:0] phase_err = '0, freq_err = '0;
    logic              ext_mode = 1'b1, init_cmd = 1'b0;
    logic [9:0]        acq_phase_pre = 10'd5, trk_phase_pre = '0;
    logic [9:0]        acq_fl_pre = 10'd100, trk_fl_pre = '0;
    logic [5:0]        acq_period = 6'd8, trk_period = 6'd4;
    logic [2:0]        verify_n = 3'd2, sweep_n = 3'd3;
    logic              locked, sweep_en, track_sel, int_pulse;
    logic [9:0]        phase_acc, fl_acc;
    logic [1:0]        state_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam int N_VEC = 8;
    localparam int VEC_PH[N_VEC] = '{3, -10, -128, 127, 0, -1, 50, -2};
    localparam int VEC_FR[N_VEC] = '{-4, 7, 0, -128, 1, -1, -60, 20};
    localparam int EXP_PH[N_VEC] = '{8, 18, 145, 272, 272, 273, 323, 325};
    localparam int EXP_FR[N_VEC] = '{104, 111, 111, 238, 239, 240, 300, 320};

    always #2.5 clk = ~clk;

    carrier_lock_fsm u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .phase_err(phase_err),
        .freq_err(freq_err), .ext_mode(ext_mode), .init_cmd(init_cmd),
        .acq_phase_pre(acq_phase_pre), .trk_phase_pre(trk_phase_pre),
        .acq_fl_pre(acq_fl_pre), .trk_fl_pre(trk_fl_pre),
        .acq_period(acq_period), .trk_period(trk_period),
        .verify_n(verify_n), .sweep_n(sweep_n), .locked(locked),
        .sweep_en(sweep_en), .track_sel(track_sel), .int_pulse(int_pulse),
        .phase_acc(phase_acc), .fl_acc(fl_acc), .state_out(state_out)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic smp(int ph, int fr);
        phase_err = 8'(ph);
        freq_err  = 8'(fr);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic init_pulse();
        init_cmd = 1'b1;
        @(negedge clk);
        init_cmd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 state", state_out, 0);
        check("R1 locked", locked, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sweep_en", sweep_en, 1);
        check("R1 track_sel", track_sel, 0);
        check("R1 int_pulse", int_pulse, 0);
        check("R1 phase preload", phase_acc, 5);
        check("R1 fl preload", fl_acc, 100);

        // R2 table of magnitudes in external mode, period of 8 samples
        for (int i = 0; i < N_VEC; i++) begin
            smp(VEC_PH[i], VEC_FR[i]);
            check("R2 phase sum", phase_acc, EXP_PH[i]);
            check("R2 fl sum", fl_acc, EXP_FR[i]);
        end
        check("R11 int after period", int_pulse, 1);
        check("R10 state frozen", state_out, 0);
        smp(9, 9);
        check("R10 phase held", phase_acc, 325);
        check("R10 fl held", fl_acc, 320);
        check("R11 single pulse", int_pulse, 0);
        init_pulse();
        check("R9 init phase", phase_acc, 5);
        check("R9 init fl", fl_acc, 100);
        phase_err = 8'sd40;
        @(negedge clk);
        check("R2 valid low", phase_acc, 5);

        // automatic mode
        ext_mode = 1'b0;
        acq_period = 6'd4;
        acq_fl_pre = '0;
        acq_phase_pre = 10'd1000;
        init_pulse();
        smp(30, 0);
        check("R3 search carry stays", state_out, 0);
        check("R3 search carry reload", phase_acc, 1000);
        trk_phase_pre = 10'd7;
        for (int i = 0; i < 4; i++) smp(0, 0);
        check("R3 to verify", state_out, 1);
        check("R3 sweep off", sweep_en, 0);
        check("R3 track on", track_sel, 1);
        check("R9 track preload", phase_acc, 7);
        check("R11 no int auto", int_pulse, 0);
        acq_phase_pre = '0;
        for (int i = 0; i < 4; i++) smp(1, 0);
        check("R4 one clean period", state_out, 1);
        for (int i = 0; i < 4; i++) smp(1, 0);
        check("R4 lock state", state_out, 3);
        check("R7 locked out", locked, 1);
        trk_fl_pre = 10'd1000;
        init_pulse();
        for (int i = 0; i < 4; i++) smp(1, -128);
        check("R7 fl carry ignored", state_out, 3);
        check("R7 still locked", locked, 1);
        trk_phase_pre = 10'd1000;
        init_pulse();
        for (int i = 0; i < 3; i++) smp(1, 0);
        check("R8 pre carry", phase_acc, 1003);
        smp(30, 0);
        check("R8 carry beats rollover", state_out, 0);
        check("R8 lock dropped", locked, 0);
        check("R9 acq reload", phase_acc, 0);

        // false lock escape
        trk_phase_pre = '0;
        trk_fl_pre = '0;
        for (int i = 0; i < 4; i++) smp(0, 0);
        check("R3 re-verify", state_out, 1);
        trk_fl_pre = 10'd1000;
        acq_fl_pre = 10'd1000;
        init_pulse();
        smp(0, -128);
        check("R5 sweep state", state_out, 2);
        check("R5 sweep on", sweep_en, 1);
        check("R5 acq set", track_sel, 0);
        check("R9 sweep fl preload", fl_acc, 1000);
        for (int i = 0; i < 11; i++) smp(0, -128);
        check("R6 still sweeping", state_out, 2);
        smp(0, -128);
        check("R6 back to search", state_out, 0);

        finish_run();
    end
endmodule